// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that exposes a small internal bank of byte-wide registers (up to 128) to a bus host. SCL and SDA are brought into the system clock domain through two-flop synchronisers. START, STOP and the SCL edges are then found from the synchronised samples. The block answers to one fixed 7-bit device address. The first byte written after the address is a pointer byte: its low seven bits select a register, and its top bit decides whether the pointer steps forward after each data byte.

A write transfer stores every byte after the pointer byte into the register that the pointer selects. A read is done in two parts. A write phase first sets the pointer. A repeated START and the address with the read bit follow. The block then returns register contents for as long as the host acknowledges. SDA is modelled as an active-high pull-down enable: 1 drives the line low and 0 releases it.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the block releases SDA and acknowledges nothing until a START has been seen. Bytes that are clocked without a preceding START get no acknowledge.
- R2: The first byte after a START carries the address in bits 7:1 and the direction in bit 0, where 1 means read. If the address differs from the device address, the block gives no acknowledge and keeps SDA released until the next START or STOP.
- R3: After the address byte, the pointer byte and every written data byte, the block holds SDA low for the entire high phase of the ninth clock.
- R4: In the pointer byte, bits 6:0 load the register pointer and bit 7 set to 1 enables auto-increment.
- R5: In a write, each data byte is stored into the register at the pointer. With auto-increment on, the pointer then advances by one and wraps from 127 to 0.
- R6: With auto-increment off, consecutive data bytes in a burst write or a burst read all use the same register.
- R7: After START, address+write, pointer byte, repeated START and address+read, the block sends the register at the pointer MSB first. Each host acknowledge (SDA low on the ninth clock) brings the next byte, with the pointer advanced when auto-increment is on.
- R8: A host not-acknowledge ends the read. The block then releases SDA and stays silent for any further clocks until a START or STOP.
- R9: The block changes SDA only while SCL is low, so every bit it returns stays stable through the whole SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen by the pad |
| sdaIn | input | 1 | Bus data line as seen by the pad |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest state to reach from the pins is a pointer wrap that happens in the middle of a transfer. It needs a write that starts at register 126 with auto-increment on and continues over the top of the register space. The wrapped value must then be read back through a separate read, so only bus-level evidence is used. The bench drives a bit-level host model that clocks three bytes from pointer byte 0xFE. It then reads them back as a burst and also reads register 0 alone with auto-increment off. The released line after a host not-acknowledge is reached by clocking an extra byte after the NACK and expecting all ones.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_SKIP
  } busState_t;

  typedef struct packed {
    logic shiftIn;   // take one received bit
    logic setPtr;    // load pointer and auto-increment flag
    logic writeReg;  // store received byte at pointer
    logic advance;   // step pointer if auto-increment is on
    logic loadTx;    // fetch byte at (possibly advanced) pointer
    logic shiftTx;   // present next transmit bit
  } dpCtl_t;
endpackage

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic       txMsb,
  output dpCtl_t     ctl,
  output logic       sdaS,
  output logic       sdaOe,
  output busState_t  state
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic [1:0] sclSync, sdaSync;
  logic sclQ, sdaQ, sclS;
  logic sclRise, sclFall, startSeen, stopSeen;
  logic [CNT_W-1:0] bitCnt, cntNxt;
  logic readDir, readNxt, hostAck, ackNxt, driveNxt;
  busState_t stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1; sdaSync <= '1; sclQ <= 1'b1; sdaQ <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclQ    <= sclSync[1];
      sdaQ    <= sdaSync[1];
    end
  end

  assign sclS      = sclSync[1];
  assign sdaS      = sdaSync[1];
  assign sclRise   = sclS & ~sclQ;
  assign sclFall   = ~sclS & sclQ;
  assign startSeen = sclS & sclQ & sdaQ & ~sdaS;
  assign stopSeen  = sclS & sclQ & ~sdaQ & sdaS;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    cntNxt   = bitCnt;
    readNxt  = readDir;
    ackNxt   = hostAck;
    if (startSeen) begin
      stateNxt = ST_ADDR;
      cntNxt   = '0;
    end else if (stopSeen) begin
      stateNxt = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_WR: begin
          if (sclRise) begin
            ctl.shiftIn = 1'b1;
            cntNxt      = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL) begin
            cntNxt = '0;
            if (state == ST_ADDR) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                stateNxt = ST_ADDR_ACK;
                readNxt  = rxByte[0];
              end else begin
                stateNxt = ST_SKIP;
              end
            end else if (state == ST_SUB) begin
              ctl.setPtr = 1'b1;
              stateNxt   = ST_SUB_ACK;
            end else begin
              ctl.writeReg = 1'b1;
              ctl.advance  = 1'b1;
              stateNxt     = ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          if (readDir) begin
            ctl.loadTx = 1'b1;
            stateNxt   = ST_RD;
          end else begin
            stateNxt = ST_SUB;
          end
        end
        ST_SUB_ACK, ST_WR_ACK: if (sclFall) stateNxt = ST_WR;
        ST_RD: begin
          if (sclRise) cntNxt = bitCnt + 1'b1;
          else if (sclFall) begin
            if (bitCnt == FULL) begin
              stateNxt = ST_RD_ACK;
              cntNxt   = '0;
            end else begin
              ctl.shiftTx = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) ackNxt = ~sdaS;
          else if (sclFall) begin
            if (hostAck) begin
              ctl.advance = 1'b1;
              ctl.loadTx  = 1'b1;
              stateNxt    = ST_RD;
            end else begin
              stateNxt = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign driveNxt = (state == ST_ADDR_ACK) || (state == ST_SUB_ACK) ||
                    (state == ST_WR_ACK) || (state == ST_RD && !txMsb);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      readDir <= 1'b0;
      hostAck <= 1'b0;
      sdaOe   <= 1'b0;
    end else begin
      state   <= stateNxt;
      bitCnt  <= cntNxt;
      readDir <= readNxt;
      hostAck <= ackNxt;
      sdaOe   <= driveNxt;
    end
  end
endmodule

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int REG_COUNT = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     ctl,
  input  logic       sdaBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic       txMsb,
  output logic [$clog2(REG_COUNT)-1:0] regPtr,
  output logic       autoInc
);
  localparam int PTR_W = $clog2(REG_COUNT);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(REG_COUNT - 1);

  logic [BYTE_W-1:0] regFile [REG_COUNT];
  logic [BYTE_W-1:0] txByte;
  logic [PTR_W-1:0]  ptrInc, ptrNext;

  assign ptrInc  = (regPtr == LAST) ? '0 : regPtr + 1'b1;
  assign ptrNext = (ctl.advance && autoInc) ? ptrInc : regPtr;
  assign txMsb   = txByte[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regPtr  <= '0;
      autoInc <= 1'b0;
      rxByte  <= '0;
      txByte  <= '1;
    end else begin
      if (ctl.setPtr) begin
        regPtr  <= rxByte[PTR_W-1:0];
        autoInc <= rxByte[BYTE_W-1];
      end else begin
        regPtr <= ptrNext;
      end
      if (ctl.shiftIn) rxByte <= {rxByte[BYTE_W-2:0], sdaBit};
      if (ctl.loadTx)       txByte <= regFile[ptrNext];
      else if (ctl.shiftTx) txByte <= {txByte[BYTE_W-2:0], 1'b1};
    end
  end

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regFile[i] <= '0;
      else if (ctl.writeReg && regPtr == PTR_W'(i)) regFile[i] <= rxByte;
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h2A,
  parameter int         REG_COUNT = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDriveLow
);
  localparam int PTR_W = $clog2(REG_COUNT);

  dpCtl_t            dpCtl;
  busState_t         busState;
  logic [BYTE_W-1:0] rxByte;
  logic              txMsb, sdaSynced, autoInc;
  logic [PTR_W-1:0]  regPtr;

  i2c_tgt_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txMsb(txMsb), .ctl(dpCtl), .sdaS(sdaSynced),
    .sdaOe(sdaDriveLow), .state(busState)
  );

  i2c_tgt_dp #(.REG_COUNT(REG_COUNT)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .sdaBit(sdaSynced),
    .rxByte(rxByte), .txMsb(txMsb), .regPtr(regPtr), .autoInc(autoInc)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
  import i2c_tgt_pkg::*;
#(
  parameter int REG_COUNT = 128
) (
  input logic      clk,
  input logic      rstN,
  input logic      sclIn,
  input logic      sdaOe,
  input busState_t state,
  input dpCtl_t    ctl,
  input logic [$clog2(REG_COUNT)-1:0] regPtr,
  input logic      autoInc
);
  localparam int PTR_W = $clog2(REG_COUNT);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(REG_COUNT - 1);

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> !sdaOe);

  a_r2_skip_released: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP && $past(state) == ST_SKIP) |-> !sdaOe);

  a_r3_ack_held: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ADDR_ACK || state == ST_SUB_ACK || state == ST_WR_ACK) &&
     $past(state) == state) |-> sdaOe);

  a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeReg && ctl.advance && autoInc && regPtr == LAST) |=> regPtr == '0);

  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !autoInc && !ctl.setPtr) |=> $stable(regPtr));

  a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);
endmodule

bind i2c_reg_target i2c_tgt_chk #(.REG_COUNT(REG_COUNT)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaDriveLow),
  .state(busState), .ctl(dpCtl), .regPtr(regPtr), .autoInc(autoInc)
);

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h2A;
  // each entry: pointer byte, data written, value expected on read-back
  localparam logic [23:0] VEC [6] = '{
    24'h05_3C_3C, 24'h7F_A5_A5, 24'h00_01_01,
    24'h40_FF_FF, 24'h05_C3_C3, 24'h41_00_00
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic hostLow = 1'b0;
  logic dutLow;
  logic sdaLine;
  int checks = 0;
  int errors = 0;

  assign sdaLine = ~(hostLow | dutLow);
  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_reg_target #(.DEV_ADDR(DEV), .REG_COUNT(128)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaDriveLow(dutLow)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic startC();
    if (scl == 1'b0) begin
      wq(1); hostLow = 1'b0; wq(1); scl = 1'b1;
    end
    wq(1); hostLow = 1'b1; wq(1); scl = 1'b0;
  endtask

  task automatic stopC();
    wq(1); hostLow = 1'b1; wq(1); scl = 1'b1; wq(1); hostLow = 1'b0; wq(1);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackA, output logic ackB);
    for (int i = 7; i >= 0; i--) begin
      wq(1); hostLow = ~b[i]; wq(1); scl = 1'b1; wq(2); scl = 1'b0;
    end
    wq(1); hostLow = 1'b0; wq(1); scl = 1'b1;
    @(negedge clk); ackA = ~sdaLine;
    repeat (2 * Q - 2) @(negedge clk); ackB = ~sdaLine;
    @(negedge clk); scl = 1'b0;
  endtask

  task automatic sendChk(input logic [7:0] b, input logic expAck, input string req);
    logic a0, a1;
    sendByte(b, a0, a1);
    check({req, " ack at high start"}, {7'd0, a0}, {7'd0, expAck});
    check({req, " ack at high end"}, {7'd0, a1}, {7'd0, expAck});
  endtask

  task automatic recvByte(output logic [7:0] b, input logic giveAck);
    logic early, late;
    for (int i = 7; i >= 0; i--) begin
      wq(1); hostLow = 1'b0; wq(1); scl = 1'b1;
      @(negedge clk); early = sdaLine;
      repeat (2 * Q - 2) @(negedge clk); late = sdaLine;
      @(negedge clk); scl = 1'b0;
      b[i] = early;
      check("R9 bit stable over high phase", {7'd0, late}, {7'd0, early});
    end
    wq(1); hostLow = giveAck; wq(1); scl = 1'b1; wq(2); scl = 1'b0;
  endtask

  task automatic wrBurst(input logic [7:0] sub, input logic [7:0] d [4], input int n);
    startC();
    sendChk({DEV, 1'b0}, 1'b1, "R3 address");
    sendChk(sub, 1'b1, "R3 pointer byte");
    for (int k = 0; k < n; k++) sendChk(d[k], 1'b1, "R3 data");
    stopC();
  endtask

  task automatic rdBurst(input logic [7:0] sub, input int n, output logic [7:0] q [4]);
    startC();
    sendChk({DEV, 1'b0}, 1'b1, "R7 address+W");
    sendChk(sub, 1'b1, "R7 pointer byte");
    startC();
    sendChk({DEV, 1'b1}, 1'b1, "R7 address+R");
    for (int k = 0; k < n; k++) recvByte(q[k], k < n - 1);
    wq(1);
    check("R8 released after NACK", {7'd0, dutLow}, 8'h00);
    stopC();
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] d [4];
    logic [7:0] q [4];
    logic [7:0] junk;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    wq(1);
    check("R1 SDA released after reset", {7'd0, dutLow}, 8'h00);

    // R1: a matching address clocked with no START is not acknowledged
    scl = 1'b0;
    sendChk({DEV, 1'b0}, 1'b0, "R1 no START");
    stopC();

    // table: single write, single read-back, auto-increment off (R4)
    foreach (VEC[v]) begin
      d[0] = VEC[v][15:8];
      wrBurst(VEC[v][23:16], d, 1);
      rdBurst(VEC[v][23:16], 1, q);
      check("R4 single read-back", q[0], VEC[v][7:0]);
    end

    // R2: foreign address, then a further byte, both ignored
    startC();
    sendChk({7'h15, 1'b0}, 1'b0, "R2 mismatch address");
    sendChk(8'h05, 1'b0, "R2 ignored after mismatch");
    stopC();
    rdBurst(8'h05, 1, q);
    check("R2 register untouched by ignored transfer", q[0], 8'hC3);

    // R5: auto-increment burst write across the top of the space
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
    wrBurst(8'hFE, d, 3);
    rdBurst(8'h00, 1, q);
    check("R5 wrap stored at register 0", q[0], 8'h33);
    rdBurst(8'h7F, 1, q);
    check("R5 register 127", q[0], 8'h22);
    // R7: burst read with auto-increment, also wrapping
    rdBurst(8'hFE, 3, q);
    check("R7 burst byte 0", q[0], 8'h11);
    check("R7 burst byte 1", q[1], 8'h22);
    check("R7 burst byte 2", q[2], 8'h33);

    // R6: auto-increment off keeps the same register
    d[0] = 8'h44; d[1] = 8'h55;
    wrBurst(8'h10, d, 2);
    rdBurst(8'h11, 1, q);
    check("R6 neighbour untouched", q[0], 8'h00);
    rdBurst(8'h10, 2, q);
    check("R6 burst read byte 0", q[0], 8'h55);
    check("R6 burst read byte 1", q[1], 8'h55);

    // R8: clocks after a NACK see a released line
    startC();
    sendChk({DEV, 1'b0}, 1'b1, "R8 address+W");
    sendChk(8'h10, 1'b1, "R8 pointer byte");
    startC();
    sendChk({DEV, 1'b1}, 1'b1, "R8 address+R");
    recvByte(junk, 1'b0);
    check("R8 data before NACK", junk, 8'h55);
    recvByte(junk, 1'b0);
    check("R8 silent after NACK", junk, 8'hFF);
    stopC();
    wq(2);
    check("R8 released after STOP", {7'd0, dutLow}, 8'h00);

    finishRun();
  end
endmodule